// File: doc/BRIEF.md
# Paged Register Window Bridge

This block is an APB3 slave placed between a host bus and the register file of an Ethernet coding-sublayer core. The target space holds 16-bit registers at 21-bit addresses: bits [20:16] name the management device (MMD) and bits [15:0] name the register inside that device. The bridge turns each APB transfer into one access on a plain internal register-file port. That port carries an address, write data, a write strobe and combinational read data.

Two address mappings can be chosen at elaboration. In the flat mapping, every target register has its own bus offset. In the paged mapping, the host sees only 256 slots. Slots 0 to 254 show the registers of one 256-register page. Slot 255 is a page-select register that holds address bits [20:8].

A second parameter sets the register spacing on the bus to 2 or 4 bytes. The data bus is as wide as the spacing, and a register value always sits in the lowest 16 bits.

Top module: `vpBridge`

## Requirements
- R1: Every transfer completes in its APB access phase (PSEL and PENABLE high) with `pready` high. `rfWe` is never high outside the access phase of an aligned write.
- R2: An access whose offset has any of its low log2(stride) bits set gets `pslverr` high in its access phase. Such an access does not pulse `rfWe`, leaves the page register unchanged and returns `prdata` of zero.
- R3: In flat mapping, the target address is offset bits [log2(stride)+20 : log2(stride)]. Offset bits above these are ignored.
- R4: In paged mapping, the slot index is offset bits [log2(stride)+7 : log2(stride)]. Slots 0 to 254 map to target address {page, slot}, where the page fills bits [20:8] and the slot fills bits [7:0].
- R5: In paged mapping, slot 255 is the page register. A write stores `pwdata[12:0]` and ignores the higher bits. A read returns the stored page zero-extended. Neither a read nor a write of slot 255 pulses `rfWe`.
- R6: A write to the page register applies to the very next transfer, including one started back to back.
- R7: An aligned write to a register-file slot pulses `rfWe` for exactly its access cycle, with `rfWdata` equal to `pwdata[15:0]`.
- R8: An aligned read of a register-file slot returns `rfRdata` in `prdata[15:0]` during the access phase.
- R9: With a 4-byte stride, `pwdata[31:16]` is ignored on writes and `prdata[31:16]` reads as zero.
- R10: After reset the page register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | PADDR_W | Byte offset into the block |
| pwdata | input | 8*STRIDE_BYTES | Write data |
| prdata | output | 8*STRIDE_BYTES | Read data, valid in the access phase |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Misalignment error, access phase only |
| rfAddr | output | 21 | Target register address {MMD, register} |
| rfWdata | output | 16 | Target write data |
| rfWe | output | 1 | Target write strobe |
| rfRdata | input | 16 | Target read data (combinational) |

## Verification
The assertions check on every cycle these properties:
- the write strobe appears only in aligned write access phases, and it forwards the low data half;
- misaligned accesses raise the error flag and suppress the strobe;
- upper read bits stay zero;
- a read returns the register-file value.

In flat mapping the assertions also check that the address equals the offset field. In paged mapping they check that the upper address bits follow the page most recently written. Only the bench's transfer sequences show the following:
- the page value after reset;
- masking of page bits on write;
- a back-to-back page change reaching the next transfer;
- that a misaligned page write leaves the stored page intact when it is read back;
- the extreme slots and MMD values.

// File: rtl/vpBridgePkg.sv
package vpBridgePkg;
  localparam int REG_W  = 16;  // target register width
  localparam int TGT_AW = 21;  // target address width
  localparam int SLOT_W = 8;   // window slot index width
  localparam int SET_W  = TGT_AW - SLOT_W; // page number width

  typedef struct packed {
    logic rfWrite;  // aligned write to a register-file slot
    logic vpWrite;  // aligned write to the page register
    logic vpSel;    // current offset addresses the page register
    logic slvErr;   // misaligned access in access phase
  } ctlStrobes_t;
endpackage

// File: rtl/vpCtrl.sv
module vpCtrl
  import vpBridgePkg::*;
#(
  parameter int STRIDE_BYTES = 2,
  parameter bit INDIRECT     = 1'b1,
  parameter int PADDR_W      = 32
) (
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  output ctlStrobes_t        strb
);
  localparam int SHIFT = (STRIDE_BYTES == 4) ? 2 : 1;

  logic accessPhase;
  logic misaligned;
  logic vpHit;
  logic unusedAddr;

  assign accessPhase = psel & penable;
  assign misaligned  = |paddr[SHIFT-1:0];
  assign unusedAddr  = ^paddr;

  generate
    if (INDIRECT) begin : g_paged
      assign vpHit = &paddr[SHIFT +: SLOT_W];
    end else begin : g_flat
      assign vpHit = 1'b0;
    end
  endgenerate

  always_comb begin
    strb.slvErr  = accessPhase & misaligned;
    strb.vpSel   = vpHit & ~misaligned;
    strb.vpWrite = accessPhase & pwrite & ~misaligned & vpHit;
    strb.rfWrite = accessPhase & pwrite & ~misaligned & ~vpHit;
  end
endmodule

// File: rtl/vpDatapath.sv
module vpDatapath
  import vpBridgePkg::*;
#(
  parameter int STRIDE_BYTES = 2,
  parameter bit INDIRECT     = 1'b1,
  parameter int PADDR_W      = 32,
  parameter int BUS_W        = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]   pwdata,
  input  logic [REG_W-1:0]   rfRdata,
  output logic [TGT_AW-1:0]  rfAddr,
  output logic [REG_W-1:0]   rfWdata,
  output logic               rfWe,
  output logic [BUS_W-1:0]   prdata
);
  localparam int SHIFT = (STRIDE_BYTES == 4) ? 2 : 1;

  logic [SET_W-1:0] viewport;
  logic [REG_W-1:0] regVal;
  logic             unusedBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             viewport <= '0;
    else if (strb.vpWrite) viewport <= pwdata[SET_W-1:0];
  end

  generate
    if (INDIRECT) begin : g_paged
      assign rfAddr = {viewport, paddr[SHIFT +: SLOT_W]};
    end else begin : g_flat
      assign rfAddr = paddr[SHIFT +: TGT_AW];
    end
  endgenerate

  always_comb regVal = strb.vpSel ? REG_W'(viewport) : rfRdata;

  always_comb begin
    prdata = '0;
    if (!strb.slvErr) prdata[REG_W-1:0] = regVal;
  end

  assign rfWdata    = pwdata[REG_W-1:0];
  assign rfWe       = strb.rfWrite;
  assign unusedBits = ^{paddr, pwdata};
endmodule

// File: rtl/vpBridge.sv
module vpBridge
  import vpBridgePkg::*;
#(
  parameter int STRIDE_BYTES = 2,
  parameter bit INDIRECT     = 1'b1,
  parameter int PADDR_W      = 32,
  parameter int BUS_W        = 8 * STRIDE_BYTES
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]   pwdata,
  output logic [BUS_W-1:0]   prdata,
  output logic               pready,
  output logic               pslverr,
  output logic [20:0]        rfAddr,
  output logic [15:0]        rfWdata,
  output logic               rfWe,
  input  logic [15:0]        rfRdata
);
  ctlStrobes_t strb;

  vpCtrl #(
    .STRIDE_BYTES(STRIDE_BYTES), .INDIRECT(INDIRECT), .PADDR_W(PADDR_W)
  ) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .strb(strb)
  );

  vpDatapath #(
    .STRIDE_BYTES(STRIDE_BYTES), .INDIRECT(INDIRECT),
    .PADDR_W(PADDR_W), .BUS_W(BUS_W)
  ) u_dp (
    .clk(pclk), .rstN(presetn), .strb(strb), .paddr(paddr), .pwdata(pwdata),
    .rfRdata(rfRdata), .rfAddr(rfAddr), .rfWdata(rfWdata), .rfWe(rfWe),
    .prdata(prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = strb.slvErr;
endmodule

// File: rtl/vpBridgeChecker.sv
module vpBridgeChecker #(
  parameter int STRIDE_BYTES = 2,
  parameter bit INDIRECT     = 1'b1,
  parameter int PADDR_W      = 32,
  parameter int BUS_W        = 16
) (
  input logic               pclk,
  input logic               presetn,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [PADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]   pwdata,
  input logic [BUS_W-1:0]   prdata,
  input logic               pslverr,
  input logic [20:0]        rfAddr,
  input logic [15:0]        rfWdata,
  input logic               rfWe,
  input logic [15:0]        rfRdata
);
  localparam int SHIFT = (STRIDE_BYTES == 4) ? 2 : 1;

  logic acc, aligned, pageSlot, unusedIn;
  logic [12:0] shadowPage;

  assign acc      = psel && penable;
  assign aligned  = (paddr[SHIFT-1:0] == '0);
  assign pageSlot = INDIRECT && (paddr[SHIFT +: 8] == 8'hFF);
  assign unusedIn = ^{paddr, pwdata, prdata};

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) shadowPage <= '0;
    else if (acc && pwrite && aligned && pageSlot) shadowPage <= pwdata[12:0];
  end

  a_r1_we_only_aligned_write: assert property (@(posedge pclk) disable iff (!presetn)
    rfWe |-> (acc && pwrite && aligned));

  a_r2_misaligned_flagged: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !aligned) |-> (pslverr && !rfWe));

  a_r2_err_in_access_only: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> acc);

  a_r7_wdata_forwarded: assert property (@(posedge pclk) disable iff (!presetn)
    rfWe |-> (rfWdata == pwdata[15:0]));

  a_r8_read_returns_rf: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !pwrite && aligned && !pageSlot) |-> (prdata[15:0] == rfRdata));

  generate
    if (INDIRECT) begin : g_paged
      a_r6_page_drives_addr: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && aligned && !pageSlot) |-> (rfAddr[20:8] == shadowPage));
    end else begin : g_flat
      a_r3_flat_addr: assert property (@(posedge pclk) disable iff (!presetn)
        acc |-> (rfAddr == paddr[SHIFT +: 21]));
    end
    if (BUS_W > 16) begin : g_wide
      a_r9_upper_read_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && !pwrite) |-> (prdata[BUS_W-1:16] == '0));
    end
  endgenerate
endmodule

bind vpBridge vpBridgeChecker #(
  .STRIDE_BYTES(STRIDE_BYTES), .INDIRECT(INDIRECT), .PADDR_W(PADDR_W), .BUS_W(BUS_W)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
  .rfAddr(rfAddr), .rfWdata(rfWdata), .rfWe(rfWe), .rfRdata(rfRdata)
);

// File: tb/test_vpBridge.sv
`timescale 1ns/1ps
module test_vpBridge;
  typedef struct {
    bit          isRead;
    bit          err;
    bit          we;
    bit          chkAddr;
    logic [20:0] addr;
    logic [15:0] wd;
    logic [31:0] rd;
    string       req;
  } exp_t;

  logic pclk = 0;
  logic presetn = 0;
  always #4 pclk = ~pclk;  // 125 MHz

  // instance A: paged, 2-byte stride
  logic aSel = 0, aEn = 0, aWr = 0;
  logic [31:0] aAddr = 0;
  logic [15:0] aWdata = 0, aRdata, aRfWdata, aRfRdata;
  logic aReady, aErr, aRfWe;
  logic [20:0] aRfAddr;

  // instance B: flat, 4-byte stride
  logic bSel = 0, bEn = 0, bWr = 0;
  logic [31:0] bAddr = 0, bWdata = 0, bRdata;
  logic [15:0] bRfWdata, bRfRdata;
  logic bReady, bErr, bRfWe;
  logic [20:0] bRfAddr;

  function automatic logic [15:0] rfModel(logic [20:0] a);
    return a[15:0] ^ {a[20:16], a[20:16], a[20:16], 1'b1};
  endfunction

  assign aRfRdata = rfModel(aRfAddr);
  assign bRfRdata = rfModel(bRfAddr);

  vpBridge i_vpBridge (
    .pclk(pclk), .presetn(presetn), .psel(aSel), .penable(aEn), .pwrite(aWr),
    .paddr(aAddr), .pwdata(aWdata), .prdata(aRdata), .pready(aReady), .pslverr(aErr),
    .rfAddr(aRfAddr), .rfWdata(aRfWdata), .rfWe(aRfWe), .rfRdata(aRfRdata)
  );

  vpBridge #(.STRIDE_BYTES(4), .INDIRECT(1'b0)) i_vpBridgeFlat (
    .pclk(pclk), .presetn(presetn), .psel(bSel), .penable(bEn), .pwrite(bWr),
    .paddr(bAddr), .pwdata(bWdata), .prdata(bRdata), .pready(bReady), .pslverr(bErr),
    .rfAddr(bRfAddr), .rfWdata(bRfWdata), .rfWe(bRfWe), .rfRdata(bRfRdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t qA[$], qB[$];
  logic [12:0] pageModel = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic score(exp_t e, logic err, logic we, logic [20:0] addr,
                       logic [15:0] wd, logic [31:0] rd, logic rdy);
    check(rdy == 1'b1, "R1", "pready", 32'(rdy), 1);
    check(err == e.err, e.req, "pslverr", 32'(err), 32'(e.err));
    check(we == e.we, e.req, "rfWe", 32'(we), 32'(e.we));
    if (e.chkAddr) check(addr == e.addr, e.req, "rfAddr", 32'(addr), 32'(e.addr));
    if (e.we) check(wd == e.wd, e.req, "rfWdata", 32'(wd), 32'(e.wd));
    if (e.isRead) check(rd == e.rd, e.req, "prdata", rd, e.rd);
  endtask

  // monitors
  always @(negedge pclk) begin
    if (presetn && aSel && aEn) begin
      if (qA.size() == 0) check(0, "R1", "unexpected A access", 0, 0);
      else score(qA.pop_front(), aErr, aRfWe, aRfAddr, aRfWdata, 32'(aRdata), aReady);
    end
    if (presetn && aSel && !aEn) check(!aRfWe, "R1", "A strobe in setup", 32'(aRfWe), 0);
    if (presetn && bSel && bEn) begin
      if (qB.size() == 0) check(0, "R1", "unexpected B access", 0, 0);
      else score(qB.pop_front(), bErr, bRfWe, bRfAddr, bRfWdata, bRdata, bReady);
    end
  end

  // driver A: paged window, slot = addr[8:1], page register at slot 255
  task automatic xferA(bit wr, logic [31:0] addr, logic [15:0] data, string req);
    exp_t e;
    logic [7:0] slot = addr[8:1];
    e.req = req; e.isRead = !wr; e.wd = data; e.err = addr[0];
    e.we = 0; e.chkAddr = 0; e.rd = 0; e.addr = 0;
    if (!e.err && slot == 8'hFF) begin
      e.rd = 32'(pageModel);
    end else if (!e.err) begin
      e.addr = {pageModel, slot}; e.chkAddr = 1; e.we = wr; e.rd = 32'(rfModel(e.addr));
    end
    qA.push_back(e);
    if (wr && !e.err && slot == 8'hFF) pageModel = data[12:0];
    @(posedge pclk); #1;
    aSel = 1; aEn = 0; aWr = wr; aAddr = addr; aWdata = data;
    @(posedge pclk); #1;
    aEn = 1;
  endtask

  // driver B: flat map, register = addr[22:2]
  task automatic xferB(bit wr, logic [31:0] addr, logic [31:0] data, string req);
    exp_t e;
    e.req = req; e.isRead = !wr; e.wd = data[15:0]; e.err = |addr[1:0];
    e.addr = addr[22:2]; e.chkAddr = !e.err; e.we = wr && !e.err;
    e.rd = e.err ? 32'h0 : 32'(rfModel(addr[22:2]));
    qB.push_back(e);
    @(posedge pclk); #1;
    bSel = 1; bEn = 0; bWr = wr; bAddr = addr; bWdata = data;
    @(posedge pclk); #1;
    bEn = 1;
  endtask

  task automatic idleA(); @(posedge pclk); #1; aSel = 0; aEn = 0; endtask
  task automatic idleB(); @(posedge pclk); #1; bSel = 0; bEn = 0; endtask

  initial begin
    repeat (3) @(posedge pclk);
    #1;
    check(aRfWe == 0 && aErr == 0, "R10", "reset strobes A", {aRfWe, aErr}, 0);
    check(bRfWe == 0 && bErr == 0, "R10", "reset strobes B", {bRfWe, bErr}, 0);
    presetn = 1;

    // paged instance
    xferA(0, 32'h1FE, 16'h0, "R10");     // page reads 0 after reset
    xferA(1, 32'h1FE, 16'hE5A7, "R5");   // page <- 0x05A7, upper bits dropped
    xferA(0, 32'h020, 16'h0, "R6");      // back-to-back: slot 0x10 under new page
    xferA(1, 32'h084, 16'h1234, "R7");   // slot 0x42 write
    xferA(0, 32'h1FC, 16'h0, "R4");      // slot 254 is a register
    xferA(0, 32'h1FE, 16'h0, "R5");      // page read back
    xferA(1, 32'h1FF, 16'h0FFF, "R2");   // misaligned page write
    xferA(0, 32'h1FE, 16'h0, "R2");      // page unchanged
    xferA(1, 32'h1FE, 16'h1FFF, "R5");   // max page
    xferA(1, 32'h000, 16'hA5A5, "R4");   // slot 0 -> 0x1FFF00
    xferA(0, 32'h003, 16'h0, "R2");      // misaligned read
    xferA(1, 32'h1FE, 16'h0000, "R6");
    xferA(0, 32'h006, 16'h0, "R4");      // slot 3 in page 0
    xferA(0, 32'hFFFF_FE08, 16'h0, "R4"); // bits above slot ignored: slot 4
    idleA();

    // flat instance
    xferB(0, 32'h0, 32'h0, "R3");
    xferB(0, 32'h007F_FFFC, 32'h0, "R3");       // last register, MMD 31
    xferB(1, 32'h0028_48D0, 32'hDEAD_BEEF, "R9"); // upper data half ignored
    xferB(0, 32'h0000_0028, 32'h0, "R9");        // upper read half zero
    xferB(0, 32'h0000_0006, 32'h0, "R2");
    xferB(1, 32'h0000_0401, 32'h1111_2222, "R2");
    xferB(0, 32'h0040_0000, 32'h0, "R3");        // MMD 16, register 0
    xferB(1, 32'hFF80_0010, 32'h0000_7777, "R3"); // bits above field ignored
    xferB(0, 32'h0000_0010, 32'h0, "R8");
    idleB();

    repeat (3) @(posedge pclk);
    check(qA.size() == 0 && qB.size() == 0, "R1", "pending items", qA.size() + qB.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge pclk);
        check(0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule